// File: doc/BRIEF.md
# Ethernet Frame Payload Extractor

This block pulls the payload out of one raw Ethernet frame held in a byte-wide memory. A start command supplies the frame's base address in the source memory and a base address in the destination memory. The block reads the eight header bytes and checks them: seven preamble bytes of 0xAA, then a delimiter byte of 0xAB. It then reads a big-endian 16-bit length word and rejects any frame whose length is above the configured maximum. Only a frame that passes every check has its payload copied, byte by byte and in ascending order, into the destination memory.

The block talks to two simple synchronous memory ports. The read port has one cycle of latency. The write port takes one byte per cycle. During the copy the block issues one read per cycle and writes each returned byte one cycle later, so the payload moves at full port rate. The end of an operation is marked by a one-cycle `done` pulse, and `status` carries the result (0 for success, 1 for error). While an operation is in progress, any new start command is ignored. MAC addresses and the frame check sequence are not examined.

Top module: `fx_payload_mover`

## Requirements
- R1: While reset is held, and directly after it, `busy`, `done`, `rd_en` and `wr_en` are low and `status` is 0.
- R2: Each byte at source offsets 0 to 6 must equal 0xAA. A mismatch at any of these offsets ends the operation with `done` and `status`=1, and no byte is written.
- R3: The byte at source offset 7 must equal 0xAB. Any other value ends the operation with `status`=1 and no writes.
- R4: The payload length is byte[src+20]*256 + byte[src+21], so the byte at offset 20 is the high byte.
- R5: A length greater than MAX_LEN (default 1500) ends the operation with `status`=1 and no writes. A length equal to MAX_LEN is accepted.
- R6: For a valid frame, byte[src+22+i] is written to address dst+i for each i from 0 to length-1. Each byte is written exactly once, in ascending order of i, and addresses wrap modulo 2^AW.
- R7: A length of zero completes with `status`=0 and no writes.
- R8: `done` is high for exactly one cycle per operation. `status` (0 = success, 1 = error) changes only in the cycle in which `done` is high, and it holds its value until the next operation completes.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation keeps its own base addresses and finishes normally.
- R10: Timing, counting `done` relative to the clock edge that accepts `start`: with a nonzero length L, `done` goes high 12+L cycles later; with a zero length or an oversize length it goes high 11 cycles later; with a header mismatch at offset k it goes high k+2 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| src_base | input | AW | Frame base address in source memory |
| dst_base | input | AW | Payload base address in destination memory |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse marking the end of an operation |
| status | output | 1 | Result of the last operation: 0 success, 1 error |
| rd_en | output | 1 | Source memory read request |
| rd_addr | output | AW | Source memory read address |
| rd_data | input | 8 | Source memory data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Destination memory write strobe |
| wr_addr | output | AW | Destination memory write address |
| wr_data | output | 8 | Destination memory write data |

## Verification
The bench builds the block with AW=12 and the default MAX_LEN of 1500. With AW=12 a 4 KiB source memory can hold the longest legal frame, so the bench can copy exactly 1500 bytes and can place 1501 and larger lengths right next to that case. It also uses destination bases near the top of the address space to make the write addresses wrap. The bench corrupts each of the eight header offsets in turn and sweeps lengths that cross the high/low byte boundary (255, 256, 257). For every run it checks the exact cycle of `done` against the arithmetic latency.

// File: rtl/fx_pkg.sv
// fx_pkg: shared state encoding and status codes for the payload mover.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package fx_pkg;
    typedef enum logic [2:0] {
        FX_IDLE,   // waiting for start
        FX_HDR,    // issuing header reads at offsets 0..PRE_N
        FX_LHI,    // issuing read of length high byte
        FX_LLO,    // issuing read of length low byte
        FX_LEVAL,  // both length bytes available, decide
        FX_COPY,   // one payload read per cycle
        FX_DRAIN   // last payload byte being written
    } fx_state_e;

    localparam logic FX_OK  = 1'b0;
    localparam logic FX_ERR = 1'b1;
endpackage

// File: rtl/fx_hdr_cmp.sv
// fx_hdr_cmp: compares one returned header byte against the value its offset
// requires (preamble byte below PRE_N, delimiter byte at PRE_N).
// Assumes: idx never exceeds PRE_N while the result is used.
module fx_hdr_cmp #(
    parameter int          PRE_N    = 7,
    parameter logic [7:0]  PRE_BYTE = 8'hAA,
    parameter logic [7:0]  SFD_BYTE = 8'hAB,
    localparam int         IW       = $clog2(PRE_N + 1)
) (
    input  logic [IW-1:0] idx,
    input  logic [7:0]    byte_in,
    output logic          ok
);
    // select the expected value by offset and compare
    always_comb begin
        if (idx < IW'(PRE_N)) ok = (byte_in == PRE_BYTE);
        else                  ok = (byte_in == SFD_BYTE);
    end
endmodule

// File: rtl/fx_len_eval.sv
// fx_len_eval: assembles the big-endian length word and classifies it.
// Assumes: hi arrives from offset LEN_OFS and lo from LEN_OFS+1.
module fx_len_eval #(
    parameter int MAX_LEN = 1500,
    parameter int LW      = 16
) (
    input  logic [7:0]    hi,
    input  logic [7:0]    lo,
    output logic [LW-1:0] len,
    output logic          too_big,
    output logic          empty
);
    // high byte first, then compare against the limit
    always_comb begin
        len     = LW'({hi, lo});
        too_big = (len > LW'(MAX_LEN));
        empty   = (len == '0);
    end
endmodule

// File: rtl/fx_wr_pipe.sv
// fx_wr_pipe: delays a copy read request by the one-cycle memory latency and
// turns it into a write strobe and destination address.
// Assumes: dst_base stays stable for the whole operation.
module fx_wr_pipe #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [CW-1:0] idx,
    input  logic [AW-1:0] dst_base,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr
);
    logic          vld_q;
    logic [CW-1:0] idx_q;

    // align the write with the read data returning one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            idx_q <= '0;
        end else begin
            vld_q <= issue;
            idx_q <= idx;
        end
    end

    assign wr_en   = vld_q;
    assign wr_addr = dst_base + AW'(idx_q);

    // R6
    wr_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(issue));
endmodule

// File: rtl/fx_payload_mover.sv
// fx_payload_mover: checks the header of one raw frame in source memory, reads
// its length word and copies the payload to destination memory.
// Assumes: read memory has exactly one cycle of latency; write memory accepts
// one byte per cycle; base addresses wrap modulo 2^AW.
module fx_payload_mover #(
    parameter int AW      = 16,
    parameter int MAX_LEN = 1500,
    parameter int PRE_N   = 7,
    parameter int LEN_OFS = 20,
    parameter int PAY_OFS = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    output logic          busy,
    output logic          done,
    output logic          status,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    import fx_pkg::*;

    localparam int LW = 16;
    localparam int CW = LW;
    localparam int IW = $clog2(PRE_N + 1);

    fx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] src_q, dst_q;
    logic [7:0]    len_hi_q;
    logic [LW-1:0] len_q;
    logic          chk_vld_q;
    logic [IW-1:0] chk_idx_q;
    logic          done_q, status_q;

    logic          hdr_ok, hdr_bad, issue;
    logic [LW-1:0] len_w;
    logic          too_big, empty;

    fx_hdr_cmp #(.PRE_N(PRE_N)) u_hdr (
        .idx(chk_idx_q), .byte_in(rd_data), .ok(hdr_ok)
    );

    fx_len_eval #(.MAX_LEN(MAX_LEN), .LW(LW)) u_len (
        .hi(len_hi_q), .lo(rd_data), .len(len_w), .too_big(too_big), .empty(empty)
    );

    fx_wr_pipe #(.AW(AW), .CW(CW)) u_wr (
        .clk(clk), .rst_n(rst_n), .issue(issue), .idx(cnt_q),
        .dst_base(dst_q), .wr_en(wr_en), .wr_addr(wr_addr)
    );

    assign hdr_bad = chk_vld_q && !hdr_ok;

    // read address and request per state
    always_comb begin
        rd_en   = 1'b0;
        rd_addr = src_q;
        issue   = 1'b0;
        case (state_q)
            FX_HDR:  begin rd_en = 1'b1; rd_addr = src_q + AW'(cnt_q); end
            FX_LHI:  begin rd_en = 1'b1; rd_addr = src_q + AW'(LEN_OFS); end
            FX_LLO:  begin rd_en = 1'b1; rd_addr = src_q + AW'(LEN_OFS + 1); end
            FX_COPY: begin
                rd_en   = 1'b1;
                rd_addr = src_q + AW'(PAY_OFS) + AW'(cnt_q);
                issue   = 1'b1;
            end
            default: ;
        endcase
    end

    // sequencing: header walk, length decision, copy, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FX_IDLE;
            cnt_q     <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            len_hi_q  <= '0;
            len_q     <= '0;
            chk_vld_q <= 1'b0;
            chk_idx_q <= '0;
            done_q    <= 1'b0;
            status_q  <= FX_OK;
        end else begin
            done_q    <= 1'b0;
            chk_vld_q <= (state_q == FX_HDR) && !hdr_bad;
            chk_idx_q <= cnt_q[IW-1:0];
            if (hdr_bad) begin
                state_q  <= FX_IDLE;
                done_q   <= 1'b1;
                status_q <= FX_ERR;
            end else begin
                case (state_q)
                    FX_IDLE: if (start) begin
                        src_q   <= src_base;
                        dst_q   <= dst_base;
                        cnt_q   <= '0;
                        state_q <= FX_HDR;
                    end
                    FX_HDR: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(PRE_N)) state_q <= FX_LHI;
                    end
                    FX_LHI: state_q <= FX_LLO;
                    FX_LLO: begin
                        len_hi_q <= rd_data;
                        state_q  <= FX_LEVAL;
                    end
                    FX_LEVAL: begin
                        len_q <= len_w;
                        cnt_q <= '0;
                        if (too_big) begin
                            state_q  <= FX_IDLE;
                            done_q   <= 1'b1;
                            status_q <= FX_ERR;
                        end else if (empty) begin
                            state_q  <= FX_IDLE;
                            done_q   <= 1'b1;
                            status_q <= FX_OK;
                        end else begin
                            state_q <= FX_COPY;
                        end
                    end
                    FX_COPY: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == len_q - 1'b1) state_q <= FX_DRAIN;
                    end
                    FX_DRAIN: begin
                        state_q  <= FX_IDLE;
                        done_q   <= 1'b1;
                        status_q <= FX_OK;
                    end
                    default: state_q <= FX_IDLE;
                endcase
            end
        end
    end

    assign busy    = (state_q != FX_IDLE);
    assign done    = done_q;
    assign status  = status_q;
    assign wr_data = rd_data;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status));
    // R6
    wr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1)));
    // R5
    oversize_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FX_LEVAL && too_big) |=> (!busy && !wr_en && status));
    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(src_q));
    // R1
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);
endmodule

// File: tb/tb_fx_payload_mover.sv
module tb_fx_payload_mover;
    localparam int AW  = 12;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic          busy, done, status, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0]    rd_data, wr_data;
    logic [7:0]    mem [MSZ];

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    fx_payload_mover #(.AW(AW), .MAX_LEN(1500)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
        .dst_base(dst_base), .busy(busy), .done(done), .status(status),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int i, input int seed);
        return 8'((i * 13 + seed) & 8'hFF);
    endfunction

    // bad_pos < 0: intact header; exp_err: expected status
    task automatic run(input int src, input int dst, input int len,
                       input int bad_pos, input int bad_val, input bit inject,
                       input bit exp_err, input string req);
        int n, idx, exp_n, exp_cnt;
        bit data_ok, seen;
        for (int k = 0; k < 7; k++) mem[(src + k) % MSZ] = 8'hAA;
        mem[(src + 7) % MSZ] = 8'hAB;
        for (int k = 8; k < 20; k++) mem[(src + k) % MSZ] = 8'h5A;
        if (bad_pos >= 0) mem[(src + bad_pos) % MSZ] = 8'(bad_val);
        mem[(src + 20) % MSZ] = 8'(len >> 8);
        mem[(src + 21) % MSZ] = 8'(len);
        if (!exp_err) for (int i = 0; i < len; i++) mem[(src + 22 + i) % MSZ] = pay(i, src);
        exp_cnt = exp_err ? 0 : len;
        if (bad_pos >= 0)      exp_n = bad_pos + 3;
        else if (exp_err || len == 0) exp_n = 12;
        else                   exp_n = 13 + len;
        @(negedge clk);
        start = 1'b1; src_base = AW'(src); dst_base = AW'(dst);
        @(negedge clk);
        start = 1'b0; n = 1; idx = 0; data_ok = 1'b1; seen = 1'b0;
        forever begin
            if (wr_en) begin
                if (wr_addr != AW'(dst + idx) || wr_data != pay(idx, src)) data_ok = 1'b0;
                idx++;
            end
            if (done) begin seen = 1'b1; break; end
            if (n > 3000) break;
            if (inject && n == 5) begin start = 1'b1; src_base = '0; dst_base = '0; end
            else start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(seen, req, seen, 1);
        chk(status == exp_err, req, status, exp_err);
        chk(idx == exp_cnt, req, idx, exp_cnt);
        chk(data_ok, {req, " R6 data/addr"}, data_ok, 1);
        chk(n == exp_n, {req, " R10 latency"}, n, exp_n);
        @(negedge clk);
        chk(!done, "R8 done width", done, 0);
        chk(status == exp_err, "R8 status hold", status, exp_err);
    endtask

    initial begin
        for (int i = 0; i < MSZ; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !rd_en && !wr_en && !status, "R1 reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en && !status, "R1 after reset", busy, 0);
        // R4 R6 R7 R10 length sweep
        run(16,   100,  0,    -1, 0, 0, 0, "R7 zero");
        run(40,   200,  1,    -1, 0, 0, 0, "R6 len1");
        run(41,   300,  2,    -1, 0, 0, 0, "R6 len2");
        run(77,   4090, 3,    -1, 0, 0, 0, "R6 wrap");
        run(90,   500,  5,    -1, 0, 0, 0, "R6 len5");
        run(300,  4070, 64,   -1, 0, 0, 0, "R6 wrap64");
        run(500,  900,  255,  -1, 0, 0, 0, "R4 len255");
        run(800,  1200, 256,  -1, 0, 0, 0, "R4 len256");
        run(1100, 1500, 257,  -1, 0, 0, 0, "R4 len257");
        run(1,    2000, 1499, -1, 0, 0, 0, "R5 len1499");
        run(2,    2100, 1500, -1, 0, 0, 0, "R5 len1500");
        // R5 oversize
        run(10,   100,  1501,   -1, 0, 0, 1, "R5 len1501");
        run(20,   100,  16'h600, -1, 0, 0, 1, "R5 len1536");
        run(30,   100,  16'hFFFF, -1, 0, 0, 1, "R5 lenFFFF");
        // R2 R3 header faults at every offset
        for (int k = 0; k < 7; k++) run(50 + k, 100, 4, k, 8'hAB, 0, 1, "R2 preamble");
        run(60, 100, 4, 7, 8'hAA, 0, 1, "R3 delimiter AA");
        run(61, 100, 4, 7, 8'h2B, 0, 1, "R3 delimiter 2B");
        // R9 start while busy
        run(700, 3000, 20, -1, 0, 1, 0, "R9 start busy");
        run(710, 3100, 0,  3, 8'h00, 1, 1, "R9 start busy err");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=0", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end
endmodule